// File: doc/BRIEF.md
# Configurable AND-OR Logic Array with Typed Output Nodes

This block is a programmable two-level logic array. A bank of internal signals first passes through a router. The router places each signal onto one of the array inputs, or keeps it away from the array. A set of product terms samples those array inputs. Each term is a ternary cube that can require an input to be low, require it to be high, or ignore it. Every term may be given to one output node. Each node combines the terms it owns according to a type code. A node can also pick up one or two signals from the bank directly. The node then applies a buffer mode that can pass, invert, or turn the sum into an XOR or XNOR form.

All configuration goes through one write strobe. This port has no ready signal and so never applies back-pressure: each cycle with `cfg_we` high is taken at the next rising edge. A write to an index that does not exist is dropped. The signal bank and the node outputs are plain parallel buses with no handshake. The path from `sig_in` to `node_out` is purely combinational. A configuration change shows at the outputs after the clock edge that stores it. An illegal type or buffer code raises a sticky error flag, and the node that holds the code drives 0.

Top module: `pla_array`

## Requirements
- R1: After reset, every node output is 0, `cfg_err` is 0, no term is owned by a node, and no signal is routed to the array.
- R2: A cube write (kind 0) to term t stores the value in `cfg_data[5:0]` and the care mask in `cfg_data[11:6]`. Bit i of each field refers to array input i. The term is true when every input whose care bit is 1 equals its value bit. A term with a care mask of all zeros is always true.
- R3: An owner write (kind 1) to term t assigns it to node `cfg_data[1:0]` when `cfg_data[2]` is 1, and frees it when that bit is 0. A term belongs to at most one node at a time.
- R4: A route write (kind 3) to signal s connects it to array input `cfg_data[2:0]` when `cfg_data[3]` is 1. An input that no signal reaches reads 0. An input that several signals reach reads their OR. An input index of 6 or above connects to nothing.
- R5: Node types 2, 3, 4 and 13 produce the OR of the node's owned terms. With no owned term the result is 0.
- R6: Type 5 produces 0 and type 6 produces 1, before the buffer stage.
- R7: A node write (kind 2) stores the type in `cfg_data[3:0]`, the buffer in `cfg_data[6:4]`, pin A in `cfg_data[9:7]` and pin B in `cfg_data[12:10]`. Type 7 outputs pin A, type 9 outputs pin A AND pin B, and type 10 outputs pin A OR pin B.
- R8: Type 8 outputs pin A AND the node's array result. Type 12 outputs pin A XOR that result.
- R9: Buffer 1 passes the type result unchanged. Buffer 2 inverts it after the terms are combined, so one all-ones term under buffer 2 gives the NAND of all inputs.
- R10: Under buffer 3, the array result is the node's lowest-indexed owned term XOR the OR of its other owned terms. Buffer 4 uses the same array result and inverts the final output.
- R11: A node with type 0 or buffer 0 drives 0.
- R12: A node write to an existing node with a type code outside {0,2,3,4,5,6,7,8,9,10,12,13}, or a buffer code above 4, sets `cfg_err` at the next edge. The flag stays set until reset, and that node drives 0.
- R13: A write takes effect at the rising edge that samples it, and not before. Node outputs follow `sig_in` with no clock delay.
- R14: A write whose index lies beyond the entries of its kind changes no output and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, always accepted |
| cfg_kind | input | 2 | Entry kind: 0 cube, 1 owner, 2 node, 3 route |
| cfg_idx | input | 3 | Term, node or signal index of the entry |
| cfg_data | input | 13 | Entry contents, field layout set by kind |
| sig_in | input | 8 | Internal signal bank |
| node_out | output | 4 | One result bit per OR node |
| cfg_err | output | 1 | Sticky illegal-code flag |

## Verification
The assertions assume that `rst_n` is held low across at least one rising edge before use. They also assume that `cfg_kind`, `cfg_idx` and `cfg_data` carry known values whenever `cfg_we` is high, because the write and error properties compare stored fields against the sampled data. The bench drives every configuration field with known values and changes the strobe and the signal bank only on falling edges. Each output is then sampled one time step after a falling edge, so the combinational array has settled and no configuration write is mid-flight.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  typedef enum logic [1:0] {
    KIND_CUBE  = 2'd0,
    KIND_OWNER = 2'd1,
    KIND_NODE  = 2'd2,
    KIND_ROUTE = 2'd3
  } cfg_kind_e;

  localparam int TYPE_W = 4;
  localparam int BUF_W  = 3;

  localparam logic [TYPE_W-1:0] NT_OFF      = 4'd0;
  localparam logic [TYPE_W-1:0] NT_SUM_A    = 4'd2;
  localparam logic [TYPE_W-1:0] NT_SUM_B    = 4'd3;
  localparam logic [TYPE_W-1:0] NT_SUM_C    = 4'd4;
  localparam logic [TYPE_W-1:0] NT_ZERO     = 4'd5;
  localparam logic [TYPE_W-1:0] NT_ONE      = 4'd6;
  localparam logic [TYPE_W-1:0] NT_PIN      = 4'd7;
  localparam logic [TYPE_W-1:0] NT_PIN_AND  = 4'd8;
  localparam logic [TYPE_W-1:0] NT_PAIR_AND = 4'd9;
  localparam logic [TYPE_W-1:0] NT_PAIR_OR  = 4'd10;
  localparam logic [TYPE_W-1:0] NT_PIN_XOR  = 4'd12;
  localparam logic [TYPE_W-1:0] NT_SUM_D    = 4'd13;

  localparam logic [BUF_W-1:0] BF_OFF  = 3'd0;
  localparam logic [BUF_W-1:0] BF_PASS = 3'd1;
  localparam logic [BUF_W-1:0] BF_INV  = 3'd2;
  localparam logic [BUF_W-1:0] BF_XOR  = 3'd3;
  localparam logic [BUF_W-1:0] BF_XNOR = 3'd4;

  function automatic logic type_ok(input logic [TYPE_W-1:0] t);
    case (t)
      NT_OFF, NT_SUM_A, NT_SUM_B, NT_SUM_C, NT_ZERO, NT_ONE, NT_PIN,
      NT_PIN_AND, NT_PAIR_AND, NT_PAIR_OR, NT_PIN_XOR, NT_SUM_D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic buf_ok(input logic [BUF_W-1:0] b);
    return (b <= BF_XNOR);
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 6,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter int N_SIG  = 8,
  parameter int IDXW   = 3,
  parameter int DW     = 13,
  parameter int OW     = 2,
  parameter int SW     = 3,
  parameter int PW     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [1:0]                          cfg_kind,
  input  logic [IDXW-1:0]                     cfg_idx,
  input  logic [DW-1:0]                       cfg_data,
  output logic [N_TERM-1:0][N_IN-1:0]         cube_care,
  output logic [N_TERM-1:0][N_IN-1:0]         cube_val,
  output logic [N_TERM-1:0]                   own_en,
  output logic [N_TERM-1:0][OW-1:0]           own_node,
  output logic [N_OUT-1:0][TYPE_W-1:0]        node_type,
  output logic [N_OUT-1:0][BUF_W-1:0]         node_buf,
  output logic [N_OUT-1:0][SW-1:0]            node_pa,
  output logic [N_OUT-1:0][SW-1:0]            node_pb,
  output logic [N_SIG-1:0]                    route_en,
  output logic [N_SIG-1:0][PW-1:0]            route_in,
  output logic                                cfg_err
);

  localparam int BUF_LO = TYPE_W;
  localparam int PA_LO  = TYPE_W + BUF_W;
  localparam int PB_LO  = PA_LO + SW;

  logic [TYPE_W-1:0] wr_type;
  logic [BUF_W-1:0]  wr_buf;
  logic              wr_node_hit;

  assign wr_type     = cfg_data[TYPE_W-1:0];
  assign wr_buf      = cfg_data[BUF_LO +: BUF_W];
  assign wr_node_hit = cfg_we && (cfg_kind == KIND_NODE) && (int'(cfg_idx) < N_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cube_care <= '0;
      cube_val  <= '0;
      own_en    <= '0;
      own_node  <= '0;
    end else if (cfg_we) begin
      for (int t = 0; t < N_TERM; t++) begin
        if (cfg_idx == IDXW'(t)) begin
          if (cfg_kind == KIND_CUBE) begin
            cube_val[t]  <= cfg_data[N_IN-1:0];
            cube_care[t] <= cfg_data[2*N_IN-1:N_IN];
          end else if (cfg_kind == KIND_OWNER) begin
            own_node[t] <= cfg_data[OW-1:0];
            own_en[t]   <= cfg_data[OW];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_type <= '0;
      node_buf  <= '0;
      node_pa   <= '0;
      node_pb   <= '0;
    end else if (wr_node_hit) begin
      for (int n = 0; n < N_OUT; n++) begin
        if (cfg_idx == IDXW'(n)) begin
          node_type[n] <= wr_type;
          node_buf[n]  <= wr_buf;
          node_pa[n]   <= cfg_data[PA_LO +: SW];
          node_pb[n]   <= cfg_data[PB_LO +: SW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_en <= '0;
      route_in <= '0;
    end else if (cfg_we && (cfg_kind == KIND_ROUTE)) begin
      for (int s = 0; s < N_SIG; s++) begin
        if (cfg_idx == IDXW'(s)) begin
          route_in[s] <= cfg_data[PW-1:0];
          route_en[s] <= cfg_data[PW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
    end else if (wr_node_hit && (!type_ok(wr_type) || !buf_ok(wr_buf))) begin
      cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_IN   = 6,
  parameter int N_TERM = 8,
  parameter int N_SIG  = 8,
  parameter int PW     = 3
) (
  input  logic [N_SIG-1:0]              sig_in,
  input  logic [N_SIG-1:0]              route_en,
  input  logic [N_SIG-1:0][PW-1:0]      route_in,
  input  logic [N_TERM-1:0][N_IN-1:0]   cube_care,
  input  logic [N_TERM-1:0][N_IN-1:0]   cube_val,
  output logic [N_TERM-1:0]             term_hit
);

  logic [N_IN-1:0] pla_in;

  always_comb begin
    pla_in = '0;
    for (int s = 0; s < N_SIG; s++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (route_en[s] && (route_in[s] == PW'(i))) begin
          pla_in[i] = pla_in[i] | sig_in[s];
        end
      end
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_cube
    assign term_hit[t] = &(~cube_care[t] | ~(pla_in ^ cube_val[t]));
  end

endmodule

// File: rtl/pla_or_node.sv
`timescale 1ns/1ps
module pla_or_node
  import pla_pkg::*;
#(
  parameter int N_TERM  = 8,
  parameter int N_SIG   = 8,
  parameter int OW      = 2,
  parameter int SW      = 3,
  parameter int NODE_ID = 0
) (
  input  logic [N_TERM-1:0]          term_hit,
  input  logic [N_TERM-1:0]          own_en,
  input  logic [N_TERM-1:0][OW-1:0]  own_node,
  input  logic [TYPE_W-1:0]          ntype,
  input  logic [BUF_W-1:0]           nbuf,
  input  logic [SW-1:0]              pa_sel,
  input  logic [SW-1:0]              pb_sel,
  input  logic [N_SIG-1:0]           sig_in,
  output logic                       y
);

  logic seen, lead, tail, arr, pin_a, pin_b, raw, flip, live;

  always_comb begin
    seen = 1'b0;
    lead = 1'b0;
    tail = 1'b0;
    for (int t = 0; t < N_TERM; t++) begin
      if (own_en[t] && (own_node[t] == OW'(NODE_ID))) begin
        if (!seen) begin
          lead = term_hit[t];
          seen = 1'b1;
        end else begin
          tail = tail | term_hit[t];
        end
      end
    end
  end

  assign arr   = ((nbuf == BF_XOR) || (nbuf == BF_XNOR)) ? (lead ^ tail) : (lead | tail);
  assign pin_a = sig_in[pa_sel];
  assign pin_b = sig_in[pb_sel];

  always_comb begin
    case (ntype)
      NT_SUM_A, NT_SUM_B, NT_SUM_C, NT_SUM_D: raw = arr;
      NT_ONE:      raw = 1'b1;
      NT_PIN:      raw = pin_a;
      NT_PIN_AND:  raw = pin_a & arr;
      NT_PAIR_AND: raw = pin_a & pin_b;
      NT_PAIR_OR:  raw = pin_a | pin_b;
      NT_PIN_XOR:  raw = pin_a ^ arr;
      default:     raw = 1'b0;
    endcase
  end

  assign flip = (nbuf == BF_INV) || (nbuf == BF_XNOR);
  assign live = type_ok(ntype) && buf_ok(nbuf) && (ntype != NT_OFF) && (nbuf != BF_OFF);
  assign y    = live & (raw ^ flip);

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 6,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter int N_SIG  = 8,
  localparam int OW    = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int SW    = (N_SIG > 1) ? $clog2(N_SIG) : 1,
  localparam int PW    = $clog2(N_IN + 1),
  localparam int MAXN  = (N_TERM > N_OUT) ? ((N_TERM > N_SIG) ? N_TERM : N_SIG)
                                          : ((N_OUT > N_SIG) ? N_OUT : N_SIG),
  localparam int IDXW  = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int DW_A  = 2 * N_IN,
  localparam int DW_B  = TYPE_W + BUF_W + 2 * SW,
  localparam int DW_C  = ((OW + 1) > (PW + 1)) ? (OW + 1) : (PW + 1),
  localparam int DW_AB = (DW_A > DW_B) ? DW_A : DW_B,
  localparam int DW    = (DW_AB > DW_C) ? DW_AB : DW_C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [DW-1:0]     cfg_data,
  input  logic [N_SIG-1:0]  sig_in,
  output logic [N_OUT-1:0]  node_out,
  output logic              cfg_err
);

  logic [N_TERM-1:0][N_IN-1:0]  cube_care, cube_val;
  logic [N_TERM-1:0]            own_en;
  logic [N_TERM-1:0][OW-1:0]    own_node;
  logic [N_OUT-1:0][TYPE_W-1:0] node_type;
  logic [N_OUT-1:0][BUF_W-1:0]  node_buf;
  logic [N_OUT-1:0][SW-1:0]     node_pa, node_pb;
  logic [N_SIG-1:0]             route_en;
  logic [N_SIG-1:0][PW-1:0]     route_in;
  logic [N_TERM-1:0]            term_hit;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .N_SIG(N_SIG),
    .IDXW(IDXW), .DW(DW), .OW(OW), .SW(SW), .PW(PW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cube_care(cube_care), .cube_val(cube_val),
    .own_en(own_en), .own_node(own_node),
    .node_type(node_type), .node_buf(node_buf),
    .node_pa(node_pa), .node_pb(node_pb),
    .route_en(route_en), .route_in(route_in),
    .cfg_err(cfg_err)
  );

  pla_and_plane #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_SIG(N_SIG), .PW(PW)
  ) u_plane (
    .sig_in(sig_in), .route_en(route_en), .route_in(route_in),
    .cube_care(cube_care), .cube_val(cube_val), .term_hit(term_hit)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_node
    pla_or_node #(
      .N_TERM(N_TERM), .N_SIG(N_SIG), .OW(OW), .SW(SW), .NODE_ID(n)
    ) u_node (
      .term_hit(term_hit), .own_en(own_en), .own_node(own_node),
      .ntype(node_type[n]), .nbuf(node_buf[n]),
      .pa_sel(node_pa[n]), .pb_sel(node_pb[n]),
      .sig_in(sig_in), .y(node_out[n])
    );
  end

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk
  import pla_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int IDXW  = 3,
  parameter int DW    = 13
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [1:0]                   cfg_kind,
  input logic [IDXW-1:0]              cfg_idx,
  input logic [DW-1:0]                cfg_data,
  input logic [N_OUT-1:0][TYPE_W-1:0] node_type,
  input logic [N_OUT-1:0][BUF_W-1:0]  node_buf,
  input logic [N_OUT-1:0]             node_out,
  input logic                         cfg_err
);

  // R12: once raised, the flag holds until reset
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R12: an illegal code written to an existing node raises the flag
  a_r12_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd2 && int'(cfg_idx) < N_OUT &&
     (!type_ok(cfg_data[TYPE_W-1:0]) || !buf_ok(cfg_data[TYPE_W +: BUF_W])))
    |=> cfg_err);

  // R14: a node write beyond the last node leaves the flag unchanged
  a_r14_no_err_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd2 && int'(cfg_idx) >= N_OUT && !cfg_err) |=> !cfg_err);

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    // R13: a node write is stored at the sampling edge
    a_r13_node_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_kind == 2'd2 && cfg_idx == IDXW'(k)) |=>
      (node_type[k] == $past(cfg_data[TYPE_W-1:0]) &&
       node_buf[k] == $past(cfg_data[TYPE_W +: BUF_W])));

    // R11: unused nodes drive 0
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (node_type[k] == NT_OFF || node_buf[k] == BF_OFF) |-> !node_out[k]);

    // R12: a node holding an illegal code drives 0
    a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!type_ok(node_type[k]) || !buf_ok(node_buf[k])) |-> !node_out[k]);

    // R6: constant types under a pass buffer
    a_r6_const_one: assert property (@(posedge clk) disable iff (!rst_n)
      (node_type[k] == NT_ONE && node_buf[k] == BF_PASS) |-> node_out[k]);
    a_r6_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (node_type[k] == NT_ZERO && node_buf[k] == BF_PASS) |-> !node_out[k]);
  end

endmodule

bind pla_array pla_array_chk #(
  .N_OUT(N_OUT), .IDXW(IDXW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
  .cfg_idx(cfg_idx), .cfg_data(cfg_data), .node_type(node_type),
  .node_buf(node_buf), .node_out(node_out), .cfg_err(cfg_err)
);

// File: tb/pla_array_bench.sv
`timescale 1ns/1ps
module pla_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = 2'd0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [12:0] cfg_data = '0;
  logic [7:0]  sig_in = '0;
  logic [3:0]  node_out;
  logic        cfg_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pla_array u_pla_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .sig_in(sig_in),
    .node_out(node_out), .cfg_err(cfg_err)
  );

  // field builders, layouts taken from the requirements
  function automatic logic [12:0] f_cube(input logic [5:0] care, input logic [5:0] val);
    logic [12:0] d = '0;
    d[5:0] = val; d[11:6] = care;
    return d;
  endfunction
  function automatic logic [12:0] f_own(input logic [1:0] node, input logic en);
    logic [12:0] d = '0;
    d[1:0] = node; d[2] = en;
    return d;
  endfunction
  function automatic logic [12:0] f_node(input logic [3:0] ty, input logic [2:0] bf,
                                         input logic [2:0] pa, input logic [2:0] pb);
    logic [12:0] d = '0;
    d[3:0] = ty; d[6:4] = bf; d[9:7] = pa; d[12:10] = pb;
    return d;
  endfunction
  function automatic logic [12:0] f_route(input logic [2:0] inp, input logic en);
    logic [12:0] d = '0;
    d[2:0] = inp; d[3] = en;
    return d;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] idx, input logic [12:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    sig_in = v;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    apply(8'hFF);
    for (int n = 0; n < 4; n++) check("R1 reset node output", node_out[n], 1'b0);
    check("R1 reset error flag", cfg_err, 1'b0);
  endtask

  task automatic t_sum_of_terms();
    for (int s = 0; s < 6; s++) wr(2'd3, 3'(s), f_route(3'(s), 1'b1));
    wr(2'd0, 3'd0, f_cube(6'h3F, 6'h3F));
    wr(2'd0, 3'd1, f_cube(6'h3F, 6'h00));
    for (int i = 0; i < 6; i++) wr(2'd0, 3'(i + 2), f_cube(6'(1 << i), 6'(1 << i)));
    wr(2'd1, 3'd0, f_own(2'd0, 1'b1));
    wr(2'd1, 3'd1, f_own(2'd1, 1'b1));
    for (int i = 2; i < 8; i++) wr(2'd1, 3'(i), f_own(2'd2, 1'b1));
    wr(2'd2, 3'd0, f_node(4'd13, 3'd1, 3'd0, 3'd0));
    wr(2'd2, 3'd1, f_node(4'd2, 3'd1, 3'd0, 3'd0));
    wr(2'd2, 3'd2, f_node(4'd3, 3'd1, 3'd0, 3'd0));
    for (int v = 0; v < 64; v++) begin
      apply(8'(v));
      check("R2 R5 AND of all inputs", node_out[0], &v[5:0]);
      check("R2 R5 NOR of all inputs", node_out[1], ~|v[5:0]);
      check("R2 R3 R5 OR of single-input terms", node_out[2], |v[5:0]);
      check("R11 unconfigured node", node_out[3], 1'b0);
    end
  endtask

  task automatic t_invert();
    wr(2'd2, 3'd0, f_node(4'd13, 3'd2, 3'd0, 3'd0));
    apply(8'h3F); check("R9 NAND all ones", node_out[0], 1'b0);
    apply(8'h3E); check("R9 NAND one low", node_out[0], 1'b1);
    apply(8'h00); check("R9 NAND all zeros", node_out[0], 1'b1);
  endtask

  task automatic t_routing();
    wr(2'd3, 3'd0, f_route(3'd0, 1'b0));
    apply(8'h3F); check("R4 unrouted input reads 0", node_out[0], 1'b1);
    wr(2'd3, 3'd6, f_route(3'd0, 1'b1));
    apply(8'h7E); check("R4 signal 6 drives input 0", node_out[0], 1'b0);
    wr(2'd3, 3'd0, f_route(3'd0, 1'b1));
    apply(8'h3F); check("R4 two signals ORed (sig0)", node_out[0], 1'b0);
    apply(8'h7E); check("R4 two signals ORed (sig6)", node_out[0], 1'b0);
    apply(8'h3E); check("R4 two signals ORed (none)", node_out[0], 1'b1);
    wr(2'd3, 3'd6, f_route(3'd7, 1'b1));
    apply(8'h7E); check("R4 out-of-range input index", node_out[0], 1'b1);
  endtask

  task automatic t_constants();
    wr(2'd2, 3'd3, f_node(4'd5, 3'd1, 3'd0, 3'd0));
    apply(8'hFF); check("R6 type 5 zero", node_out[3], 1'b0);
    wr(2'd2, 3'd3, f_node(4'd6, 3'd1, 3'd0, 3'd0));
    apply(8'h00); check("R6 type 6 one", node_out[3], 1'b1);
    wr(2'd2, 3'd3, f_node(4'd6, 3'd2, 3'd0, 3'd0));
    apply(8'h00); check("R6 R9 inverted constant", node_out[3], 1'b0);
    wr(2'd2, 3'd3, f_node(4'd6, 3'd0, 3'd0, 3'd0));
    apply(8'h00); check("R11 buffer 0 forces 0", node_out[3], 1'b0);
  endtask

  task automatic t_pins();
    wr(2'd1, 3'd0, f_own(2'd3, 1'b1));
    for (int ty = 0; ty < 5; ty++) begin
      logic [3:0] code;
      code = (ty == 0) ? 4'd7 : (ty == 1) ? 4'd9 : (ty == 2) ? 4'd10 : (ty == 3) ? 4'd8 : 4'd12;
      wr(2'd2, 3'd3, f_node(code, 3'd1, 3'd6, 3'd7));
      for (int p = 0; p < 8; p++) begin
        logic a, b, arr, e;
        a = p[0]; b = p[1]; arr = p[2];
        apply({b, a, arr ? 6'h3F : 6'h15});
        case (ty)
          0: e = a;
          1: e = a & b;
          2: e = a | b;
          3: e = a & arr;
          default: e = a ^ arr;
        endcase
        if (ty < 3) check("R7 pin type", node_out[3], e);
        else        check("R8 pin with array type", node_out[3], e);
      end
    end
  endtask

  task automatic t_xor_buffers();
    wr(2'd1, 3'd0, f_own(2'd3, 1'b0));
    for (int i = 2; i < 5; i++) wr(2'd1, 3'(i), f_own(2'd3, 1'b1));
    wr(2'd2, 3'd3, f_node(4'd4, 3'd3, 3'd0, 3'd0));
    for (int v = 0; v < 8; v++) begin
      apply(8'(v));
      check("R10 XOR buffer first term vs rest", node_out[3], v[0] ^ (v[1] | v[2]));
    end
    wr(2'd2, 3'd3, f_node(4'd4, 3'd4, 3'd0, 3'd0));
    for (int v = 0; v < 8; v++) begin
      apply(8'(v));
      check("R10 XNOR buffer", node_out[3], ~(v[0] ^ (v[1] | v[2])));
    end
  endtask

  task automatic t_latency();
    wr(2'd2, 3'd3, f_node(4'd5, 3'd1, 3'd0, 3'd0));
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'd2; cfg_idx = 3'd3; cfg_data = f_node(4'd6, 3'd1, 3'd0, 3'd0);
    #1;
    check("R13 no effect before edge", node_out[3], 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R13 effect after edge", node_out[3], 1'b1);
  endtask

  task automatic t_illegal();
    do_reset();
    apply(8'hFF);
    check("R1 config cleared by reset", node_out[0], 1'b0);
    check("R1 error cleared by reset", cfg_err, 1'b0);
    wr(2'd2, 3'd1, f_node(4'd11, 3'd1, 3'd0, 3'd0));
    check("R12 illegal type raises flag", cfg_err, 1'b1);
    check("R12 illegal type node output", node_out[1], 1'b0);
    wr(2'd2, 3'd1, f_node(4'd6, 3'd1, 3'd0, 3'd0));
    check("R12 flag stays set", cfg_err, 1'b1);
    check("R6 legal rewrite drives 1", node_out[1], 1'b1);
    do_reset();
    wr(2'd2, 3'd2, f_node(4'd6, 3'd5, 3'd0, 3'd0));
    check("R12 illegal buffer raises flag", cfg_err, 1'b1);
    check("R12 illegal buffer node output", node_out[2], 1'b0);
  endtask

  task automatic t_out_of_range();
    do_reset();
    wr(2'd2, 3'd5, f_node(4'd6, 3'd1, 3'd0, 3'd0));
    apply(8'h00);
    for (int n = 0; n < 4; n++) check("R14 node index 5 ignored", node_out[n], 1'b0);
    wr(2'd2, 3'd4, f_node(4'd11, 3'd1, 3'd0, 3'd0));
    check("R14 no flag from missing node", cfg_err, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_sum_of_terms();
    t_invert();
    t_routing();
    t_constants();
    t_pins();
    t_xor_buffers();
    t_latency();
    t_illegal();
    t_out_of_range();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule